// File: doc/BRIEF.md
# PRBS Loopback Self-Test Bring-up Sequencer

This block is a small controller that places one channel of a dual-channel serial transceiver into PRBS self-test. Every action goes over a simple request/acknowledge register bus. A single start pulse launches a fixed chain of steps. The chain soft-resets the transceiver and programs the serial, driver and clock-recovery fields. It then waits for the PLL to lock and cycles the receiver enable off and on. Next it selects one of three PRBS lengths and turns the pattern generator on. It waits for the gain-control loop to settle, moves the clock-recovery frequency multiplier to its tracking value, confirms gain lock and finally issues a datapath reset.

Each field update is a read-modify-write, so bits outside the field keep their values. Every lock poll has its own bounded retry count. The gain-settle wait also ends after a fixed number of cycles, which stands in for the unit-interval budget. A request the test cannot honour (eighth-rate transmit, or an unused pattern choice) is refused at once with no bus traffic. The caller sees `busy`, then either `done` or `error`. The selected channel is presented on `chan_o` as the bus qualifier.

Top module: `prbs_bringup_seq`

## Requirements
- R1: After a synchronous active-low reset, `busy_o`, `done_o`, `error_o` and `bus_req_o` are all 0.
- R2: Every field update is a read of a register followed by a write to the same address, in which only the field bits change and all other bits keep the value that was read. A request stays asserted, with a stable address, until acknowledged.
- R3: A full run writes registers in exactly this address order: 0, 1, 2, 8, 20, 20, 7, 7, 8, then the datapath-reset register (default 0). Status register 5 is only read.
- R4: Configuration writes: reg0 bit15=1. reg1 gets {loop_bw[9:8], tx_rate[7:6], rx_rate[5:4], pll_mult[3:0]}. reg2 gets {post_tap[12:8], pre_tap[7:4], swing[3:0]}. reg8 gets eq_preset in [14:12], threshold [11:10]=2'b01 and multiplier [9:8]=2'b00.
- R5: After configuration, reg5 is read until bit0 (PLL lock) is 1. After PLL_POLL_LIMIT reads with bit0=0, `error_o` rises, the block returns to idle and no further write is made.
- R6: The receiver enable (reg20 bit2) is written 0, and then written 1.
- R7: reg7[10:8] is written with 3'b101, 3'b110 or 3'b111 for pattern_i 0, 1 or 2. A separate later write sets reg7[13]=1. pattern_i=3 raises `error_o` with no bus transaction.
- R8: The gain wait reads reg5 until bit13 is 1 or UI_TIMEOUT_CYCLES have elapsed, whichever is first. It then writes reg8[9:8]=2'b01.
- R9: After the multiplier update, reg5 bit13 is polled. After GAIN_POLL_LIMIT reads with bit13=0, `error_o` rises and the datapath reset is not issued.
- R10: A start with tx_rate_i=2'b11 (eighth rate) raises `error_o` on the next cycle with no bus transaction.
- R11: After the datapath-reset write (reg DP_RST_ADDR, bit DP_RST_BIT set), `done_o` is 1 and `busy_o` is 0. `done_o` and `error_o` hold until the next accepted start, which clears them. A start while busy is ignored. `chan_o` carries the channel latched at start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start pulse, taken only when idle |
| pattern_i | input | 2 | PRBS choice: 0=2^7-1, 1=2^23-1, 2=2^31-1 |
| channel_i | input | 1 | Channel to test |
| loop_bw_i | input | 2 | PLL loop bandwidth field |
| pll_mult_i | input | 4 | PLL multiplier field |
| tx_rate_i | input | 2 | Transmit rate field (2'b11 refused) |
| rx_rate_i | input | 2 | Receive rate field |
| post_tap_i | input | 5 | Transmit post-cursor tap |
| pre_tap_i | input | 4 | Transmit pre-cursor tap |
| swing_i | input | 4 | Transmit swing |
| eq_preset_i | input | 3 | Receive equalizer preset |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Sequence completed |
| error_o | output | 1 | Request refused or lock poll exhausted |
| chan_o | output | 1 | Channel qualifier for bus accesses |
| bus_req_o | output | 1 | Bus request, held until ack |
| bus_we_o | output | 1 | 1=write, 0=read |
| bus_addr_o | output | 5 | Register address |
| bus_wdata_o | output | 16 | Write data |
| bus_ack_i | input | 1 | Bus acknowledge (one cycle) |
| bus_rdata_i | input | 16 | Read data, valid with ack |

## Verification
Full runs are made with each of the three pattern choices, on both channels, and over register contents preset to all zeros and to all ones. These runs tell a correct field merge apart from one that clobbers or leaks neighbouring bits, and they tell the three pattern codes apart. The status responder is driven three ways: gain lock present at once, never present, or present only after the multiplier update. This separates an early exit on the lock bit from the cycle-count timeout and from the gain-poll failure. A PLL that never locks, the refused eighth-rate and unused-pattern requests, a start issued mid-run, and a recovery start after an error cover the remaining exits of the sequence.

// File: rtl/prbs_bu_pkg.sv
// Package: shared register map, field positions, command type and
// sequencer state encoding for the PRBS bring-up sequencer.
// Assumes a 16-bit register file addressed by 5 bits.
package prbs_bu_pkg;

    localparam int ADDR_W = 5;
    localparam int DATA_W = 16;

    // Register addresses the sequence depends on
    localparam logic [ADDR_W-1:0] A_CTRL   = 5'd0;
    localparam logic [ADDR_W-1:0] A_SERDES = 5'd1;
    localparam logic [ADDR_W-1:0] A_DRIVE  = 5'd2;
    localparam logic [ADDR_W-1:0] A_STAT   = 5'd5;
    localparam logic [ADDR_W-1:0] A_TEST   = 5'd7;
    localparam logic [ADDR_W-1:0] A_CDR    = 5'd8;
    localparam logic [ADDR_W-1:0] A_RXCTL  = 5'd20;

    // Status bit positions
    localparam int PLL_LOCK_BIT = 0;
    localparam int GAIN_LOCK_BIT = 13;

    // One bus operation: either plain read or read-modify-write
    typedef struct packed {
        logic              rd_only;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] mask;
        logic [DATA_W-1:0] value;
    } bus_cmd_t;

    typedef enum logic [3:0] {
        ST_IDLE, ST_SRST, ST_CFG_SER, ST_CFG_DRV, ST_CFG_CDR,
        ST_PLL_POLL, ST_RX_OFF, ST_RX_ON, ST_PAT_SEL, ST_GEN_ON,
        ST_GAIN_WAIT, ST_CDR_TRACK, ST_GAIN_POLL, ST_DP_RST
    } seq_state_e;

    // Pattern choice to select-field code; choice 3 is unused
    function automatic logic [2:0] pat_code(input logic [1:0] choice);
        case (choice)
            2'd0:    pat_code = 3'b101;
            2'd1:    pat_code = 3'b110;
            default: pat_code = 3'b111;
        endcase
    endfunction

endpackage

// File: rtl/prbs_bu_rmw.sv
// Module: read-modify-write bus engine. Takes a command while idle,
// reads the addressed register, then (unless read-only) writes back the
// read value with only the masked bits replaced. Assumes the target
// acknowledges each request with a one-cycle ack and drops ack before
// the next request is seen.
module prbs_bu_rmw
    import prbs_bu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid_i,
    input  bus_cmd_t          cmd_i,
    output logic              cmd_done_o,
    output logic              bus_req_o,
    output logic              bus_we_o,
    output logic [ADDR_W-1:0] bus_addr_o,
    output logic [DATA_W-1:0] bus_wdata_o,
    input  logic              bus_ack_i,
    input  logic [DATA_W-1:0] bus_rdata_i
);

    typedef enum logic [1:0] {E_IDLE, E_READ, E_WRITE} eng_state_e;

    eng_state_e        st_q;
    bus_cmd_t          cmd_q;
    logic [DATA_W-1:0] rd_q;

    // Engine state, command latch and read capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= E_IDLE;
            cmd_q <= '0;
            rd_q  <= '0;
        end else begin
            case (st_q)
                E_IDLE: begin
                    if (cmd_valid_i) begin
                        cmd_q <= cmd_i;
                        st_q  <= E_READ;
                    end
                end
                E_READ: begin
                    if (bus_ack_i) begin
                        rd_q <= bus_rdata_i;
                        st_q <= cmd_q.rd_only ? E_IDLE : E_WRITE;
                    end
                end
                E_WRITE: begin
                    if (bus_ack_i) begin
                        st_q <= E_IDLE;
                    end
                end
                default: st_q <= E_IDLE;
            endcase
        end
    end

    // Bus drive and completion strobe
    always_comb begin
        bus_req_o   = (st_q != E_IDLE);
        bus_we_o    = (st_q == E_WRITE);
        bus_addr_o  = cmd_q.addr;
        bus_wdata_o = (rd_q & ~cmd_q.mask) | (cmd_q.value & cmd_q.mask);
        cmd_done_o  = bus_ack_i &&
                      ((st_q == E_WRITE) || ((st_q == E_READ) && cmd_q.rd_only));
    end

    // R2: request held until acknowledged
    p_req_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req_o && !bus_ack_i) |=> bus_req_o);

    // R2: address steady while a request is waiting
    p_addr_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req_o && !bus_ack_i) |=> $stable(bus_addr_o));

    // R2: a write always follows an acknowledged read of the same address
    p_write_after_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_we_o) |-> ($past(bus_req_o) && !$past(bus_we_o) && $past(bus_ack_i)));

endmodule

// File: rtl/prbs_bu_timer.sv
// Module: saturating wait timer. Counts cycles while run_i is high and
// flags expiry after LIMIT cycles; clears whenever run_i is low.
// Assumes LIMIT >= 1.
module prbs_bu_timer #(
    parameter int LIMIT = 250_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic expired_o
);

    localparam int CNT_W = $clog2(LIMIT + 1);
    localparam logic [CNT_W-1:0] LIM_C = CNT_W'(LIMIT);

    logic [CNT_W-1:0] cnt_q;

    // Cycle counter, saturating at LIMIT
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i) begin
            cnt_q <= '0;
        end else if (cnt_q != LIM_C) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expired_o = (cnt_q == LIM_C);

    // R8: expiry only after the timer has been running
    p_expire_needs_run_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(expired_o) |-> $past(run_i));

    // R8: counter never passes its limit
    p_cnt_bounded_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LIM_C);

endmodule

// File: rtl/prbs_bu_fsm.sv
// Module: step sequencer. Walks the fixed bring-up order, builds one bus
// command per step, evaluates lock bits on poll completions and owns
// busy/done/error. Assumes the engine accepts a command only when idle.
module prbs_bu_fsm
    import prbs_bu_pkg::*;
#(
    parameter int PLL_POLL_LIMIT  = 1000,
    parameter int GAIN_POLL_LIMIT = 1000,
    parameter int DP_RST_ADDR     = 0,
    parameter int DP_RST_BIT      = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic [1:0] pattern_i,
    input  logic       channel_i,
    input  logic [1:0] loop_bw_i,
    input  logic [3:0] pll_mult_i,
    input  logic [1:0] tx_rate_i,
    input  logic [1:0] rx_rate_i,
    input  logic [4:0] post_tap_i,
    input  logic [3:0] pre_tap_i,
    input  logic [3:0] swing_i,
    input  logic [2:0] eq_preset_i,
    input  logic       cmd_done_i,
    input  logic       pll_bit_i,
    input  logic       gain_bit_i,
    input  logic       wait_expired_i,
    output logic       cmd_valid_o,
    output bus_cmd_t   cmd_o,
    output logic       wait_run_o,
    output logic       busy_o,
    output logic       done_o,
    output logic       error_o,
    output logic       chan_o
);

    localparam int POLL_MAX = (PLL_POLL_LIMIT > GAIN_POLL_LIMIT) ?
                              PLL_POLL_LIMIT : GAIN_POLL_LIMIT;
    localparam int POLL_W = $clog2(POLL_MAX + 1);
    localparam logic [POLL_W-1:0] PLL_LAST  = POLL_W'(PLL_POLL_LIMIT - 1);
    localparam logic [POLL_W-1:0] GAIN_LAST = POLL_W'(GAIN_POLL_LIMIT - 1);
    localparam logic [ADDR_W-1:0] DP_ADDR   = ADDR_W'(DP_RST_ADDR);
    localparam logic [DATA_W-1:0] DP_MASK   = DATA_W'(1) << DP_RST_BIT;

    seq_state_e        st_q;
    logic [POLL_W-1:0] poll_q;
    logic              done_q, err_q, chan_q;
    logic [2:0]        code_q;
    logic [1:0]        lbw_q, txr_q, rxr_q;
    logic [3:0]        pllm_q, pre_q, swing_q;
    logic [4:0]        post_q;
    logic [2:0]        eq_q;
    logic              refuse;

    assign refuse = (tx_rate_i == 2'b11) || (pattern_i == 2'b11);

    // Step progression, poll accounting and result flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= ST_IDLE;
            poll_q  <= '0;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
            chan_q  <= 1'b0;
            code_q  <= '0;
            lbw_q   <= '0;
            txr_q   <= '0;
            rxr_q   <= '0;
            pllm_q  <= '0;
            pre_q   <= '0;
            swing_q <= '0;
            post_q  <= '0;
            eq_q    <= '0;
        end else begin
            case (st_q)
                ST_IDLE: begin
                    if (start_i) begin
                        done_q <= 1'b0;
                        err_q  <= refuse;
                        poll_q <= '0;
                        if (!refuse) begin
                            chan_q  <= channel_i;
                            code_q  <= pat_code(pattern_i);
                            lbw_q   <= loop_bw_i;
                            txr_q   <= tx_rate_i;
                            rxr_q   <= rx_rate_i;
                            pllm_q  <= pll_mult_i;
                            pre_q   <= pre_tap_i;
                            swing_q <= swing_i;
                            post_q  <= post_tap_i;
                            eq_q    <= eq_preset_i;
                            st_q    <= ST_SRST;
                        end
                    end
                end
                ST_SRST:      if (cmd_done_i) st_q <= ST_CFG_SER;
                ST_CFG_SER:   if (cmd_done_i) st_q <= ST_CFG_DRV;
                ST_CFG_DRV:   if (cmd_done_i) st_q <= ST_CFG_CDR;
                ST_CFG_CDR:   if (cmd_done_i) st_q <= ST_PLL_POLL;
                ST_PLL_POLL: begin
                    if (cmd_done_i) begin
                        if (pll_bit_i) begin
                            poll_q <= '0;
                            st_q   <= ST_RX_OFF;
                        end else if (poll_q == PLL_LAST) begin
                            err_q <= 1'b1;
                            st_q  <= ST_IDLE;
                        end else begin
                            poll_q <= poll_q + 1'b1;
                        end
                    end
                end
                ST_RX_OFF:    if (cmd_done_i) st_q <= ST_RX_ON;
                ST_RX_ON:     if (cmd_done_i) st_q <= ST_PAT_SEL;
                ST_PAT_SEL:   if (cmd_done_i) st_q <= ST_GEN_ON;
                ST_GEN_ON:    if (cmd_done_i) st_q <= ST_GAIN_WAIT;
                ST_GAIN_WAIT: begin
                    if (cmd_done_i && (gain_bit_i || wait_expired_i)) begin
                        st_q <= ST_CDR_TRACK;
                    end
                end
                ST_CDR_TRACK: if (cmd_done_i) st_q <= ST_GAIN_POLL;
                ST_GAIN_POLL: begin
                    if (cmd_done_i) begin
                        if (gain_bit_i) begin
                            poll_q <= '0;
                            st_q   <= ST_DP_RST;
                        end else if (poll_q == GAIN_LAST) begin
                            err_q <= 1'b1;
                            st_q  <= ST_IDLE;
                        end else begin
                            poll_q <= poll_q + 1'b1;
                        end
                    end
                end
                ST_DP_RST: begin
                    if (cmd_done_i) begin
                        done_q <= 1'b1;
                        st_q   <= ST_IDLE;
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    // Command for the current step
    always_comb begin
        cmd_o = '0;
        case (st_q)
            ST_SRST: begin
                cmd_o.addr  = A_CTRL;
                cmd_o.mask  = 16'h8000;
                cmd_o.value = 16'h8000;
            end
            ST_CFG_SER: begin
                cmd_o.addr  = A_SERDES;
                cmd_o.mask  = 16'h03FF;
                cmd_o.value = {6'b0, lbw_q, txr_q, rxr_q, pllm_q};
            end
            ST_CFG_DRV: begin
                cmd_o.addr  = A_DRIVE;
                cmd_o.mask  = 16'h1FFF;
                cmd_o.value = {3'b0, post_q, pre_q, swing_q};
            end
            ST_CFG_CDR: begin
                cmd_o.addr  = A_CDR;
                cmd_o.mask  = 16'h7F00;
                cmd_o.value = {1'b0, eq_q, 2'b01, 2'b00, 8'h00};
            end
            ST_PLL_POLL, ST_GAIN_WAIT, ST_GAIN_POLL: begin
                cmd_o.rd_only = 1'b1;
                cmd_o.addr    = A_STAT;
            end
            ST_RX_OFF: begin
                cmd_o.addr  = A_RXCTL;
                cmd_o.mask  = 16'h0004;
                cmd_o.value = 16'h0000;
            end
            ST_RX_ON: begin
                cmd_o.addr  = A_RXCTL;
                cmd_o.mask  = 16'h0004;
                cmd_o.value = 16'h0004;
            end
            ST_PAT_SEL: begin
                cmd_o.addr  = A_TEST;
                cmd_o.mask  = 16'h0700;
                cmd_o.value = {5'b0, code_q, 8'h00};
            end
            ST_GEN_ON: begin
                cmd_o.addr  = A_TEST;
                cmd_o.mask  = 16'h2000;
                cmd_o.value = 16'h2000;
            end
            ST_CDR_TRACK: begin
                cmd_o.addr  = A_CDR;
                cmd_o.mask  = 16'h0300;
                cmd_o.value = 16'h0100;
            end
            ST_DP_RST: begin
                cmd_o.addr  = DP_ADDR;
                cmd_o.mask  = DP_MASK;
                cmd_o.value = DP_MASK;
            end
            default: cmd_o = '0;
        endcase
    end

    assign cmd_valid_o = (st_q != ST_IDLE);
    assign wait_run_o  = (st_q == ST_GAIN_WAIT);
    assign busy_o      = (st_q != ST_IDLE);
    assign done_o      = done_q;
    assign error_o     = err_q;
    assign chan_o      = chan_q;

    // R10: eighth-rate request refused next cycle, sequence not entered
    p_tx8_refused_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && tx_rate_i == 2'b11) |=> (error_o && !busy_o));

    // R7: unused pattern choice refused
    p_badpat_refused_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && pattern_i == 2'b11) |=> (error_o && !busy_o));

    // R11: completion and activity are exclusive
    p_done_busy_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && busy_o));

    // R11: never both success and failure
    p_done_err_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && error_o));

    // R11: channel held steady through a run
    p_chan_steady_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(busy_o) && busy_o) |-> $stable(chan_o));

endmodule

// File: rtl/prbs_bringup_seq.sv
// Module: top of the PRBS loopback bring-up sequencer. Joins the step
// sequencer, the read-modify-write bus engine and the gain-wait timer.
// Assumes a register target that answers every request with one ack.
module prbs_bringup_seq
    import prbs_bu_pkg::*;
#(
    parameter int UI_TIMEOUT_CYCLES = 250_000_000,
    parameter int PLL_POLL_LIMIT    = 1000,
    parameter int GAIN_POLL_LIMIT   = 1000,
    parameter int DP_RST_ADDR       = 0,
    parameter int DP_RST_BIT        = 3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_i,
    input  logic [1:0]  pattern_i,
    input  logic        channel_i,
    input  logic [1:0]  loop_bw_i,
    input  logic [3:0]  pll_mult_i,
    input  logic [1:0]  tx_rate_i,
    input  logic [1:0]  rx_rate_i,
    input  logic [4:0]  post_tap_i,
    input  logic [3:0]  pre_tap_i,
    input  logic [3:0]  swing_i,
    input  logic [2:0]  eq_preset_i,
    output logic        busy_o,
    output logic        done_o,
    output logic        error_o,
    output logic        chan_o,
    output logic        bus_req_o,
    output logic        bus_we_o,
    output logic [4:0]  bus_addr_o,
    output logic [15:0] bus_wdata_o,
    input  logic        bus_ack_i,
    input  logic [15:0] bus_rdata_i
);

    logic     cmd_valid, cmd_done, wait_run, wait_expired;
    bus_cmd_t cmd;

    prbs_bu_fsm #(
        .PLL_POLL_LIMIT (PLL_POLL_LIMIT),
        .GAIN_POLL_LIMIT(GAIN_POLL_LIMIT),
        .DP_RST_ADDR    (DP_RST_ADDR),
        .DP_RST_BIT     (DP_RST_BIT)
    ) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_i       (start_i),
        .pattern_i     (pattern_i),
        .channel_i     (channel_i),
        .loop_bw_i     (loop_bw_i),
        .pll_mult_i    (pll_mult_i),
        .tx_rate_i     (tx_rate_i),
        .rx_rate_i     (rx_rate_i),
        .post_tap_i    (post_tap_i),
        .pre_tap_i     (pre_tap_i),
        .swing_i       (swing_i),
        .eq_preset_i   (eq_preset_i),
        .cmd_done_i    (cmd_done),
        .pll_bit_i     (bus_rdata_i[PLL_LOCK_BIT]),
        .gain_bit_i    (bus_rdata_i[GAIN_LOCK_BIT]),
        .wait_expired_i(wait_expired),
        .cmd_valid_o   (cmd_valid),
        .cmd_o         (cmd),
        .wait_run_o    (wait_run),
        .busy_o        (busy_o),
        .done_o        (done_o),
        .error_o       (error_o),
        .chan_o        (chan_o)
    );

    prbs_bu_rmw u_rmw (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_valid_i(cmd_valid),
        .cmd_i      (cmd),
        .cmd_done_o (cmd_done),
        .bus_req_o  (bus_req_o),
        .bus_we_o   (bus_we_o),
        .bus_addr_o (bus_addr_o),
        .bus_wdata_o(bus_wdata_o),
        .bus_ack_i  (bus_ack_i),
        .bus_rdata_i(bus_rdata_i)
    );

    prbs_bu_timer #(
        .LIMIT(UI_TIMEOUT_CYCLES)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_i    (wait_run),
        .expired_o(wait_expired)
    );

    // R1: no bus request while idle
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !bus_req_o);

endmodule

// File: tb/prbs_bringup_seq_tb_top.sv
// Directed bench: a register-file responder with a scriptable status
// register, one task per scenario, each checking its own results.
module prbs_bringup_seq_tb_top;

    localparam int UI_T   = 40;
    localparam int PLL_L  = 4;
    localparam int GAIN_L = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  pattern = 2'd0;
    logic        channel = 1'b0;
    logic [1:0]  loop_bw = 2'b10, tx_rate = 2'b01, rx_rate = 2'b10;
    logic [3:0]  pll_mult = 4'h9, pre_tap = 4'hA, swing = 4'h6;
    logic [4:0]  post_tap = 5'h15;
    logic [2:0]  eq_preset = 3'b101;
    logic        busy, done, error, chan;
    logic        req, we, ack;
    logic [4:0]  addr;
    logic [15:0] wdata, rdata;

    // responder state
    logic [15:0] regs [0:31];
    logic [4:0]  wlog [0:63];
    int          wcnt, rd5cnt, txn, cyc, t_gen, t_cdrf;
    logic        cdrf_seen;
    logic [15:0] preset_v = 16'h0000;
    logic        pll_ok = 1'b1;
    int          gain_mode = 0;   // 0 always, 1 never, 2 after multiplier update
    logic        gain_now;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;   // 250 MHz

    prbs_bringup_seq #(
        .UI_TIMEOUT_CYCLES(UI_T),
        .PLL_POLL_LIMIT   (PLL_L),
        .GAIN_POLL_LIMIT  (GAIN_L),
        .DP_RST_ADDR      (0),
        .DP_RST_BIT       (3)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start), .pattern_i(pattern),
        .channel_i(channel), .loop_bw_i(loop_bw), .pll_mult_i(pll_mult),
        .tx_rate_i(tx_rate), .rx_rate_i(rx_rate), .post_tap_i(post_tap),
        .pre_tap_i(pre_tap), .swing_i(swing), .eq_preset_i(eq_preset),
        .busy_o(busy), .done_o(done), .error_o(error), .chan_o(chan),
        .bus_req_o(req), .bus_we_o(we), .bus_addr_o(addr),
        .bus_wdata_o(wdata), .bus_ack_i(ack), .bus_rdata_i(rdata)
    );

    assign gain_now = (gain_mode == 0) || (gain_mode == 2 && cdrf_seen);

    // Register responder: one-cycle ack per request, logs writes
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (!rst_n) begin
            for (int i = 0; i < 32; i++) regs[i] <= preset_v;
            ack <= 1'b0; rdata <= '0; wcnt <= 0; rd5cnt <= 0; txn <= 0;
            cdrf_seen <= 1'b0; t_gen <= 0; t_cdrf <= 0;
        end else if (req && !ack) begin
            ack <= 1'b1;
            txn <= txn + 1;
            if (we) begin
                regs[addr] <= wdata;
                if (wcnt < 64) wlog[wcnt] <= addr;
                wcnt <= wcnt + 1;
                if (addr == 5'd7 && wdata[13]) t_gen <= cyc;
                if (addr == 5'd8 && wdata[9:8] == 2'b01) begin
                    cdrf_seen <= 1'b1;
                    t_cdrf <= cyc;
                end
            end else if (addr == 5'd5) begin
                rdata <= {2'b0, gain_now, 12'b0, pll_ok};
                rd5cnt <= rd5cnt + 1;
            end else begin
                rdata <= regs[addr];
            end
        end else begin
            ack <= 1'b0;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset(input logic [15:0] pv, input logic pl, input int gm);
        @(negedge clk);
        preset_v = pv; pll_ok = pl; gain_mode = gm; rst_n = 1'b0; start = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic pulse_start(input logic [1:0] pat, input logic ch, input logic [1:0] txr);
        pattern = pat; channel = ch; tx_rate = txr;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 5000 && busy; i++) @(negedge clk);
        @(negedge clk);
    endtask

    function automatic logic [2:0] exp_code(input logic [1:0] p);
        return (p == 2'd0) ? 3'b101 : (p == 2'd1) ? 3'b110 : 3'b111;
    endfunction

    // Checks of a completed run against the register expectations
    task automatic check_full_run(input logic [1:0] pat, input logic ch, input logic [15:0] pv);
        logic [4:0] ord [0:9];
        logic [15:0] e1, e2, e8, e7, e0, e20;
        bit ord_ok;
        ord = '{5'd0, 5'd1, 5'd2, 5'd8, 5'd20, 5'd20, 5'd7, 5'd7, 5'd8, 5'd0};
        ord_ok = (wcnt == 10);
        for (int i = 0; i < 10; i++) if (wlog[i] != ord[i]) ord_ok = 0;
        chk(done && !error && !busy, "R11 done after full run", {done, error, busy}, 3'b100);
        chk(chan == ch, "R11 channel latched", chan, ch);
        chk(ord_ok, "R3 write order", wcnt, 10);
        e1  = (pv & 16'hFC00) | {6'b0, loop_bw, tx_rate, rx_rate, pll_mult};
        e2  = (pv & 16'hE000) | {3'b0, post_tap, pre_tap, swing};
        e8  = (pv & 16'h80FF) | {1'b0, eq_preset, 2'b01, 2'b01, 8'h00};
        e7  = (pv & 16'hD8FF) | 16'h2000 | {5'b0, exp_code(pat), 8'h00};
        e0  = pv | 16'h8008;
        e20 = pv | 16'h0004;
        chk(regs[1] == e1, "R4 reg1 fields merged (R2 preserve)", regs[1], e1);
        chk(regs[2] == e2, "R4 reg2 fields merged", regs[2], e2);
        chk(regs[8] == e8, "R8 reg8 final incl. multiplier 01", regs[8], e8);
        chk(regs[7] == e7, "R7 reg7 pattern code and generator bit", regs[7], e7);
        chk(regs[0] == e0, "R4 R11 soft reset and datapath reset bits", regs[0], e0);
        chk(regs[20] == e20, "R6 receiver enable ends at 1", regs[20], e20);
    endtask

    task automatic t_reset_state();
        do_reset(16'h0000, 1'b1, 0);
        chk(!busy && !done && !error && !req, "R1 reset state", {busy, done, error, req}, 0);
    endtask

    task automatic t_full(input logic [1:0] pat, input logic ch, input logic [15:0] pv);
        do_reset(pv, 1'b1, 0);
        pulse_start(pat, ch, 2'b01);
        wait_idle();
        check_full_run(pat, ch, pv);
        // R8 early exit: lock bit present, so no timeout wait
        chk((t_cdrf - t_gen) < UI_T, "R8 wait ends on lock bit", t_cdrf - t_gen, UI_T);
    endtask

    // R6: receiver enable sees a 0 write before the 1 write
    task automatic t_rx_toggle();
        logic seen_zero;
        do_reset(16'h0004, 1'b1, 0);
        seen_zero = 1'b0;
        pulse_start(2'd0, 1'b0, 2'b01);
        for (int i = 0; i < 5000 && busy; i++) begin
            @(posedge clk);
            if (req && we && !ack && addr == 5'd20 && !wdata[2]) seen_zero = 1'b1;
            @(negedge clk);
        end
        wait_idle();
        chk(seen_zero && regs[20][2], "R6 enable written 0 then 1", {seen_zero, regs[20][2]}, 2'b11);
    endtask

    task automatic t_start_busy();
        do_reset(16'h0000, 1'b1, 0);
        pulse_start(2'd0, 1'b0, 2'b01);
        repeat (10) @(negedge clk);
        pulse_start(2'd2, 1'b1, 2'b01);   // must be ignored
        wait_idle();
        chk(regs[7][10:8] == 3'b101 && wcnt == 10, "R11 start while busy ignored",
            {regs[7][10:8], wcnt[7:0]}, {3'b101, 8'd10});
        chk(chan == 1'b0, "R11 channel not changed by ignored start", chan, 0);
    endtask

    task automatic t_pll_fail();
        do_reset(16'h0000, 1'b0, 0);
        pulse_start(2'd0, 1'b0, 2'b01);
        wait_idle();
        chk(error && !done && !busy, "R5 PLL poll exhausted -> error", {error, done, busy}, 3'b100);
        chk(rd5cnt == PLL_L, "R5 number of PLL polls", rd5cnt, PLL_L);
        chk(wcnt == 4, "R5 no writes after PLL failure", wcnt, 4);
    endtask

    task automatic t_gain_timeout();
        do_reset(16'h0000, 1'b1, 2);
        pulse_start(2'd1, 1'b1, 2'b01);
        wait_idle();
        chk(done && !error, "R8 timeout path completes", {done, error}, 2'b10);
        chk((t_cdrf - t_gen) >= UI_T && (t_cdrf - t_gen) <= UI_T + 16,
            "R8 multiplier update after timeout", t_cdrf - t_gen, UI_T);
    endtask

    task automatic t_gain_fail();
        do_reset(16'h0000, 1'b1, 1);
        pulse_start(2'd2, 1'b0, 2'b01);
        wait_idle();
        chk(error && !done, "R9 gain poll exhausted -> error", {error, done}, 2'b10);
        chk(regs[8][9:8] == 2'b01, "R8 multiplier written before gain poll", regs[8][9:8], 1);
        chk(wcnt == 9 && regs[0][3] == 1'b0, "R9 no datapath reset on failure", wcnt, 9);
    endtask

    task automatic t_tx8();
        do_reset(16'h0000, 1'b1, 0);
        pulse_start(2'd0, 1'b0, 2'b11);
        chk(error && !busy, "R10 eighth rate refused", {error, busy}, 2'b10);
        repeat (5) @(negedge clk);
        chk(txn == 0, "R10 no bus transaction", txn, 0);
    endtask

    task automatic t_badpat();
        do_reset(16'h0000, 1'b1, 0);
        pulse_start(2'd3, 1'b0, 2'b01);
        repeat (5) @(negedge clk);
        chk(error && !busy && txn == 0, "R7 unused pattern refused", {error, busy, txn[0]}, 3'b100);
    endtask

    task automatic t_recover();
        // continues from the refused state of the previous scenario
        pulse_start(2'd0, 1'b1, 2'b01);
        chk(!error && busy, "R11 new start clears error", {error, busy}, 2'b01);
        wait_idle();
        chk(done && !error, "R11 run after error completes", {done, error}, 2'b10);
    endtask

    initial begin
        t_reset_state();
        t_full(2'd0, 1'b0, 16'h0000);
        t_full(2'd1, 1'b1, 16'hFFFF);
        t_full(2'd2, 1'b0, 16'hFFFF);
        t_rx_toggle();
        t_start_busy();
        t_pll_fail();
        t_gain_timeout();
        t_gain_fail();
        t_tx8();
        t_badpat();
        t_recover();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule